// File: doc/BRIEF.md
# Slow-Clock Edge Coincidence Detector

This block compares the rising edges of two slow clocks, a local one and a reference one, and reports whether they line up. Both slow clocks are sampled on the rising and the falling edge of a faster clock, so the gap between two rising edges is measured in half fast-clock cycles. The block judges each pair of rising edges against a tolerance window and drives a status flag. The flag is 0 while the pairs are coincident and 1 once a pair is not.

A mode input picks one of two windows: a wide one of two half-cycles, or a tight one of one half-cycle. An enable input turns the detector on. While the detector is off, the flag reads 0 and no measurement is in progress. The slow clocks are expected to run no faster than a quarter of the fast clock. Both slow inputs pass through the same number of synchronizer stages before edge detection, so the extra delay does not change the measured gap.

Top module: `slow_edge_coincidence`

## Requirements
- R1: While rst_n is low, and on the first cycles after it is released, sync_flag is 0.
- R2: While det_en is 0, sync_flag is 0 and no measurement is pending. After det_en returns to 1, sync_flag stays 0 until a new edge pair has been judged.
- R3: Both slow inputs are sampled on both fast-clock edges. Edges that fall in the same half-cycle, or one half-cycle apart, are judged in sync in both modes.
- R4: With tight_mode = 0, a pair whose rising edges are more than 2 half-cycles apart sets sync_flag to 1. A pair 2 or fewer half-cycles apart sets it to 0.
- R5: With tight_mode = 1, a pair whose rising edges are more than 1 half-cycle apart sets sync_flag to 1. A pair 1 or fewer half-cycles apart sets it to 0.
- R6: The verdict depends only on the size of the gap. It does not depend on which slow clock rises first.
- R7: If one slow clock rises and the other does not rise within the next 4 half-cycles, the pair is judged out of sync (sync_flag = 1). This covers the case where only one slow clock is toggling.
- R8: sync_flag holds its value between verdicts, including while both slow clocks are idle. It returns to 0 when an in-window pair is judged after an out-of-sync one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast sampling clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_loc | input | 1 | Local slow clock |
| slow_ref | input | 1 | Reference slow clock |
| det_en | input | 1 | Detector enable, active high |
| tight_mode | input | 1 | 0 selects the 2 half-cycle window, 1 selects the 1 half-cycle window |
| sync_flag | output | 1 | 1 means out of sync, 0 means in sync or detector off |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, window limits of two and one half-cycles, and a four half-cycle partner timeout. It drives both slow clocks with a 16 half-cycle period. It sweeps the reference offset from -6 to +6 half-cycles in both modes and with both half-cycle phases of the local edge. This covers every gap on both sides of each window limit, both edge orders, and gaps past the timeout. The remaining runs cover each clock toggling alone, a hold with both clocks idle, recovery to in-sync, and disable and re-enable.

// File: rtl/sec_pkg.sv
package sec_pkg;

  localparam int NCH    = 2;
  localparam int CH_LOC = 0;
  localparam int CH_REF = 1;

  // width that holds separations up to tmo+1 with margin
  function automatic int sec_sep_width(input int tmo_half);
    return $clog2(tmo_half + 2) + 1;
  endfunction

  // window verdict: 1 means the gap lies outside the selected window
  function automatic logic sec_outside(input int sep, input logic tight,
                                       input int wide_lim, input int tight_lim);
    int lim;
    lim = tight ? tight_lim : wide_lim;
    return sep > lim;
  endfunction

  // timeout reached once the checked span meets the limit
  function automatic logic sec_span_done(input int span, input int tmo_half);
    return span >= tmo_half;
  endfunction

endpackage

// File: rtl/sec_dual_edge_sampler.sv
module sec_dual_edge_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pos_q,
  output logic neg_q
);

  logic [STAGES-1:0] pos_sh;
  logic [STAGES-1:0] neg_sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_sh <= '0;
        else        pos_sh <= din;
      end
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_sh <= '0;
        else        neg_sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_sh <= '0;
        else        pos_sh <= {pos_sh[STAGES-2:0], din};
      end
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_sh <= '0;
        else        neg_sh <= {neg_sh[STAGES-2:0], din};
      end
    end
  endgenerate

  assign pos_q = pos_sh[STAGES-1];
  assign neg_q = neg_sh[STAGES-1];

endmodule

// File: rtl/sec_rise_finder.sv
module sec_rise_finder (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_q,
  input  logic neg_q,
  output logic rise_a,
  output logic rise_b
);

  // Per fast cycle two half-slots are seen in time order:
  // slot A = pos_q (older), slot B = neg_q (newer).
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= neg_q;
  end

  assign rise_a = pos_q & ~last_q;
  assign rise_b = neg_q & ~pos_q;

endmodule

// File: rtl/sec_sep_meter.sv
module sec_sep_meter
  import sec_pkg::*;
#(
  parameter int WIDE_HALF  = 2,
  parameter int TIGHT_HALF = 1,
  parameter int TMO_HALF   = 4,
  localparam int SEP_W     = sec_sep_width(TMO_HALF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tight,
  input  logic [NCH-1:0]   rise_a,
  input  logic [NCH-1:0]   rise_b,
  output logic             verdict_vld,
  output logic             verdict_bad,
  output logic             verdict_tmo,
  output logic [SEP_W-1:0] verdict_sep,
  output logic             busy
);

  logic             busy_q, nxt_busy;
  logic             first_q, nxt_first;
  logic [SEP_W-1:0] el_q, nxt_el;
  logic             c_a, c_b;

  assign c_a = rise_a[1];
  assign c_b = rise_b[1];

  always_comb begin
    nxt_busy    = busy_q;
    nxt_first   = first_q;
    nxt_el      = el_q;
    verdict_vld = 1'b0;
    verdict_tmo = 1'b0;
    verdict_sep = '0;
    if (!en) begin
      nxt_busy = 1'b0;
      nxt_el   = '0;
    end else if (!busy_q) begin
      if (&rise_a) begin
        verdict_vld = 1'b1;
      end else if (|rise_a) begin
        if (rise_b[~c_a]) begin
          verdict_vld = 1'b1;
          verdict_sep = SEP_W'(1);
        end else begin
          nxt_busy  = 1'b1;
          nxt_first = c_a;
          nxt_el    = SEP_W'(1);
        end
      end else if (&rise_b) begin
        verdict_vld = 1'b1;
      end else if (|rise_b) begin
        nxt_busy  = 1'b1;
        nxt_first = c_b;
        nxt_el    = '0;
      end
    end else begin
      if (rise_a[~first_q]) begin
        verdict_vld = 1'b1;
        verdict_sep = el_q + SEP_W'(1);
        nxt_busy    = 1'b0;
      end else if (rise_b[~first_q]) begin
        verdict_vld = 1'b1;
        verdict_sep = el_q + SEP_W'(2);
        nxt_busy    = 1'b0;
      end else if (sec_span_done(int'(el_q) + 2, TMO_HALF)) begin
        verdict_vld = 1'b1;
        verdict_tmo = 1'b1;
        verdict_sep = el_q + SEP_W'(2);
        nxt_busy    = 1'b0;
      end else begin
        nxt_el = el_q + SEP_W'(2);
      end
    end
  end

  assign verdict_bad = verdict_vld &
                       (verdict_tmo |
                        sec_outside(int'(verdict_sep), tight, WIDE_HALF, TIGHT_HALF));
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      el_q    <= '0;
    end else begin
      busy_q  <= nxt_busy;
      first_q <= nxt_first;
      el_q    <= nxt_el;
    end
  end

endmodule

// File: rtl/slow_edge_coincidence.sv
module slow_edge_coincidence
  import sec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIDE_HALF   = 2,
  parameter int TIGHT_HALF  = 1,
  parameter int TMO_HALF    = 4
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic slow_loc,
  input  logic slow_ref,
  input  logic det_en,
  input  logic tight_mode,
  output logic sync_flag
);

  localparam int SEP_W = sec_sep_width(TMO_HALF);

  logic [NCH-1:0]   slow_in;
  logic [NCH-1:0]   smp_pos, smp_neg;
  logic [NCH-1:0]   rise_a, rise_b;
  logic             verdict_vld, verdict_bad, verdict_tmo, meas_busy;
  logic [SEP_W-1:0] verdict_sep;
  logic             flag_q;

  assign slow_in[CH_LOC] = slow_loc;
  assign slow_in[CH_REF] = slow_ref;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      sec_dual_edge_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .din   (slow_in[g]),
        .pos_q (smp_pos[g]),
        .neg_q (smp_neg[g])
      );
      sec_rise_finder u_rise (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .pos_q  (smp_pos[g]),
        .neg_q  (smp_neg[g]),
        .rise_a (rise_a[g]),
        .rise_b (rise_b[g])
      );
    end
  endgenerate

  sec_sep_meter #(
    .WIDE_HALF  (WIDE_HALF),
    .TIGHT_HALF (TIGHT_HALF),
    .TMO_HALF   (TMO_HALF)
  ) u_meter (
    .clk         (clk_fast),
    .rst_n       (rst_n),
    .en          (det_en),
    .tight       (tight_mode),
    .rise_a      (rise_a),
    .rise_b      (rise_b),
    .verdict_vld (verdict_vld),
    .verdict_bad (verdict_bad),
    .verdict_tmo (verdict_tmo),
    .verdict_sep (verdict_sep),
    .busy        (meas_busy)
  );

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (!det_en)     flag_q <= 1'b0;
    else if (verdict_vld) flag_q <= verdict_bad;
  end

  assign sync_flag = det_en & flag_q;

endmodule

// File: rtl/slow_edge_coincidence_chk.sv
module slow_edge_coincidence_chk #(
  parameter int TMO_HALF = 4,
  parameter int SEP_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_en,
  input logic             sync_flag,
  input logic             verdict_vld,
  input logic             verdict_bad,
  input logic             verdict_tmo,
  input logic [SEP_W-1:0] verdict_sep,
  input logic             meas_busy
);

  p_reen_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_en) |-> !sync_flag);

  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !meas_busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !verdict_vld) |=> (!det_en || $stable(sync_flag)));

  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && verdict_vld) |=> (!det_en || sync_flag == $past(verdict_bad)));

  p_tmo_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_tmo |-> (verdict_vld && verdict_bad));

  p_sep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && !verdict_tmo) |-> (int'(verdict_sep) <= TMO_HALF + 1));

  p_coincident_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && !verdict_tmo && verdict_sep == '0) |-> !verdict_bad);

endmodule

bind slow_edge_coincidence slow_edge_coincidence_chk #(
  .TMO_HALF (TMO_HALF),
  .SEP_W    (SEP_W)
) u_chk (
  .clk         (clk_fast),
  .rst_n       (rst_n),
  .det_en      (det_en),
  .sync_flag   (sync_flag),
  .verdict_vld (verdict_vld),
  .verdict_bad (verdict_bad),
  .verdict_tmo (verdict_tmo),
  .verdict_sep (verdict_sep),
  .meas_busy   (meas_busy)
);

// File: tb/slow_edge_coincidence_tb.sv
`timescale 1ns/1ps
module slow_edge_coincidence_tb;

  localparam int PER = 16;     // slow period in half fast-cycles
  localparam int WIDE = 2;
  localparam int TIGHT = 1;

  logic clk_fast = 1'b0;
  logic rst_n = 1'b0;
  logic slow_loc = 1'b0, slow_ref = 1'b0;
  logic det_en = 1'b0, tight_mode = 1'b0;
  logic sync_flag;

  int n_chk = 0, n_err = 0;
  int slot = 0;
  int off_loc = 0, off_ref = 0;
  bit run_loc = 1'b0, run_ref = 1'b0;

  slow_edge_coincidence u_dut (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .slow_loc   (slow_loc),
    .slow_ref   (slow_ref),
    .det_en     (det_en),
    .tight_mode (tight_mode),
    .sync_flag  (sync_flag)
  );

  always #5 clk_fast = ~clk_fast;

  function automatic bit wave(int s, int off);
    int m;
    m = (s - off) % PER;
    if (m < 0) m += PER;
    return m < PER / 2;
  endfunction

  function automatic bit expect_bad(int gap, bit tight);
    int a;
    a = (gap < 0) ? -gap : gap;
    return a > (tight ? TIGHT : WIDE);
  endfunction

  task automatic step(int n);
    repeat (n) begin
      @(clk_fast);
      #2.5;
      slot++;
      slow_loc = run_loc ? wave(slot, off_loc) : 1'b0;
      slow_ref = run_ref ? wave(slot, off_ref) : 1'b0;
    end
  endtask

  task automatic chk(logic got, logic exp, string req, string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    det_en = 1'b1;
    run_loc = 1'b1;
    run_ref = 1'b1;
    #1;
    step(12);
    chk(sync_flag, 1'b0, "R1", "flag during reset");
    rst_n = 1'b1;
    step(1);
    chk(sync_flag, 1'b0, "R1", "flag just after reset");

    // sweep: both modes, both half-cycle phases, gaps -6..+6
    for (int t = 0; t < 2; t++) begin
      for (int base = 0; base < 2; base++) begin
        for (int d = -6; d <= 6; d++) begin
          tight_mode = t[0];
          off_loc = base;
          off_ref = base + d;
          step(6 * PER);
          if (d == 0 || d == 1 || d == -1)
            chk(sync_flag, 1'b0, "R3", $sformatf("coincident gap %0d mode %0d", d, t));
          else if (d < 0)
            chk(sync_flag, expect_bad(d, t[0]), "R6",
                $sformatf("ref-first gap %0d mode %0d", d, t));
          else if (t == 0)
            chk(sync_flag, expect_bad(d, 1'b0), "R4", $sformatf("wide gap %0d", d));
          else
            chk(sync_flag, expect_bad(d, 1'b1), "R5", $sformatf("tight gap %0d", d));
        end
      end
    end

    // R8: out of sync, then clocks idle: flag holds
    tight_mode = 1'b0;
    off_loc = 0;
    off_ref = 4;
    step(6 * PER);
    chk(sync_flag, 1'b1, "R8", "out of sync before idle");
    run_loc = 1'b0;
    run_ref = 1'b0;
    step(4 * PER);
    chk(sync_flag, 1'b1, "R8", "holds with both clocks idle");
    run_loc = 1'b1;
    run_ref = 1'b1;
    off_ref = 0;
    step(6 * PER);
    chk(sync_flag, 1'b0, "R8", "recovers on in-window pair");

    // R7: a single clock toggling alone
    run_ref = 1'b0;
    step(6 * PER);
    chk(sync_flag, 1'b1, "R7", "local clock alone");
    run_ref = 1'b1;
    step(6 * PER);
    chk(sync_flag, 1'b0, "R7", "back in sync before ref-alone run");
    run_loc = 1'b0;
    tight_mode = 1'b1;
    step(6 * PER);
    chk(sync_flag, 1'b1, "R7", "reference clock alone");
    run_loc = 1'b1;

    // R2: disable and re-enable
    tight_mode = 1'b0;
    off_ref = 5;
    step(6 * PER);
    chk(sync_flag, 1'b1, "R2", "out of sync before disable");
    det_en = 1'b0;
    #0.5;
    chk(sync_flag, 1'b0, "R2", "flag low at disable");
    step(4 * PER);
    chk(sync_flag, 1'b0, "R2", "flag low while disabled");
    det_en = 1'b1;
    #0.5;
    chk(sync_flag, 1'b0, "R2", "flag low right after re-enable");
    step(6 * PER);
    chk(sync_flag, 1'b1, "R2", "detector active again after re-enable");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule